// File: doc/BRIEF.md
# Programmable Interval Timer

A 16-bit down-counting timer that produces periodic interrupts and is programmed through three 16-bit registers: a control/status word, a modulus and a read-only live count. Each counter step takes a fixed number of system clocks: the base rate is the system clock divided by two, and a 4-bit prescale field divides it further by a power of two. When the counter steps while it holds zero, it reloads and sets an interrupt flag. In reload mode it reloads from the modulus, so it runs periodically. In free mode it reloads 0xFFFF.

Software clears the flag by writing 1 to it. A write to the modulus also clears the flag, and when the overwrite bit is set it loads the count at once. A control write that changes only the interrupt enable, or only clears the flag, leaves the count and the prescaler phase alone. Any other control write restarts counting from the new limit. The interrupt output is a level that is high while the flag and the enable are both set. The debug and doze bits are stored and read back but do nothing.

Register reads are combinational from the current state. Every write takes effect at the clock edge on which `wr_en` is sampled high.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word and the modulus read 0, the count reads 0xFFFF and `irq_o` is low.
- R2: While the enable bit (control bit 0) is 0, the count holds its value and the flag is never set. A modulus write with overwrite still loads the count.
- R3: Offset 0 is the control word, offset 2 is the modulus and offset 4 is the count. Writes to offset 4 are ignored. Any other offset reads 0 and ignores writes.
- R4: `irq_o` is high exactly when the flag (control bit 2) and the interrupt enable (control bit 3) are both 1.
- R5: Writing 1 to control bit 2 clears the flag. Writing 0 there leaves the flag unchanged, and software can never set the flag.
- R6: With the prescale field in control bits 11:8 set to p, the count steps once every 2^(p+1) clocks while enabled.
- R7: A step taken while the count is 0 sets the flag and reloads the count. The reload value is the modulus when the reload bit (control bit 1) is 1, and 0xFFFF when it is 0.
- R8: A modulus write always clears the flag. If the overwrite bit (control bit 4) is 1, the written value replaces the count in that same edge, taking priority over a step. Otherwise the count is untouched and the new modulus is used at the next reload.
- R9: A control write whose only changes are to the interrupt enable or the flag clear updates the register but leaves the count and the prescaler phase undisturbed.
- R10: Any other control write loads the count with the new limit (the modulus if the new reload bit is 1, else 0xFFFF) and restarts the prescaler phase. This takes priority over a step on the same edge.
- R11: The debug bit (control bit 5) and the doze bit (control bit 6) are stored and read back and have no other effect. Control bits 7 and 15:12 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 3 | Byte offset of the register accessed |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Level interrupt request |

## Verification
Register writes are visible on `rd_data` in the cycle after their write edge, and a restart or overwrite shows its loaded count in that same cycle. With prescale p, each following step lands 2^(p+1) edges later, counted from the edge that last cleared the prescaler phase. The bench drives writes on falling edges and counts the rising edges between each write and each read. It then predicts the count, the flag and the interrupt level from those edge counts alone, and pushes each prediction into a scoreboard queue. A monitor compares each prediction against the ports half a nanosecond later, still well before the next rising edge. Writes are deliberately placed on edges where a step also falls, to expose the priority of overwrite and restart over a step, and that of an interrupt-only write beside a step.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    localparam int unsigned CTL_EN     = 0;
    localparam int unsigned CTL_RLD    = 1;
    localparam int unsigned CTL_FLG    = 2;
    localparam int unsigned CTL_IE     = 3;
    localparam int unsigned CTL_OVW    = 4;
    localparam int unsigned CTL_DBG    = 5;
    localparam int unsigned CTL_DOZE   = 6;
    localparam int unsigned CTL_PRE_LO = 8;
    localparam int unsigned PRE_BITS   = 4;
    localparam int unsigned CTL_W      = 16;
    localparam int unsigned OFS_W      = 3;

    localparam logic [OFS_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [OFS_W-1:0] OFS_MOD  = 3'd2;
    localparam logic [OFS_W-1:0] OFS_CNT  = 3'd4;

    // Stored control fields (the flag lives apart: hardware sets it)
    typedef struct packed {
        logic [PRE_BITS-1:0] pre;
        logic                doze;
        logic                dbg;
        logic                ovw;
        logic                ie;
        logic                rld;
        logic                en;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [CTL_W-1:0] w);
        ctrl_t c;
        c.pre  = w[CTL_PRE_LO +: PRE_BITS];
        c.doze = w[CTL_DOZE];
        c.dbg  = w[CTL_DBG];
        c.ovw  = w[CTL_OVW];
        c.ie   = w[CTL_IE];
        c.rld  = w[CTL_RLD];
        c.en   = w[CTL_EN];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] pack_ctrl(input ctrl_t c, input logic flg);
        logic [CTL_W-1:0] w;
        w = '0;
        w[CTL_PRE_LO +: PRE_BITS] = c.pre;
        w[CTL_DOZE] = c.doze;
        w[CTL_DBG]  = c.dbg;
        w[CTL_OVW]  = c.ovw;
        w[CTL_IE]   = c.ie;
        w[CTL_FLG]  = flg;
        w[CTL_RLD]  = c.rld;
        w[CTL_EN]   = c.en;
        return w;
    endfunction

endpackage

// File: rtl/tick_timer_prescale.sv
module tick_timer_prescale #(
    parameter int unsigned PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] pre,
    output logic             tick
);
    // Phase counter wide enough for the longest period, 2^(2^PRE_W)
    localparam int unsigned DIV_W = 1 << PRE_W;

    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] term;

    always_comb begin
        span  = (DIV_W+1)'(2) << pre;               // 2^(pre+1) clocks per step
        term  = DIV_W'(span - (DIV_W+1)'(1));
        tick  = run && (div_q == term);
        div_d = div_q;
        if (restart) begin
            div_d = '0;
        end else if (run) begin
            div_d = tick ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

endmodule

// File: rtl/tick_timer_count.sv
module tick_timer_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             restart,
    input  logic [CNT_W-1:0] restart_val,
    input  logic             force_ld,
    input  logic [CNT_W-1:0] force_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap  = step && (cnt_q == '0) && !restart && !force_ld;
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = restart_val;
        end else if (force_ld) begin
            cnt_d = force_val;
        end else if (step) begin
            cnt_d = (cnt_q == '0) ? reload_val : cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       reg_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq_o
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic             flag;
        logic [CNT_W-1:0] modv;
    } regs_t;

    regs_t            regs_d, regs_q;
    ctrl_t            new_c, old_m, new_m;
    logic             ctrl_hit, mod_hit, irq_only, restart, force_ld, flag_clr;
    logic [CNT_W-1:0] restart_val, reload_val;
    logic [CNT_W-1:0] count;
    logic             step_tick, wrap_evt;

    // Signals exposed for the bound checker
    logic             flag_w, en_w, ie_w;
    logic [CTL_W-1:0] ctrl_img;

    always_comb begin
        regs_d   = regs_q;
        ctrl_hit = wr_en && (reg_addr == OFS_CTRL);
        mod_hit  = wr_en && (reg_addr == OFS_MOD);
        new_c    = unpack_ctrl(wr_data[CTL_W-1:0]);
        old_m    = regs_q.ctrl;
        old_m.ie = 1'b0;
        new_m    = new_c;
        new_m.ie = 1'b0;
        irq_only = (old_m == new_m);
        restart  = ctrl_hit && !irq_only;
        force_ld = mod_hit && regs_q.ctrl.ovw;

        restart_val = new_c.rld ? regs_q.modv : '1;
        reload_val  = regs_q.ctrl.rld ? regs_q.modv : '1;

        if (ctrl_hit) begin
            regs_d.ctrl = new_c;
        end
        if (mod_hit) begin
            regs_d.modv = wr_data;
        end
        flag_clr    = (ctrl_hit && wr_data[CTL_FLG]) || mod_hit;
        // A terminal-count event wins over a same-edge clear
        regs_d.flag = (regs_q.flag && !flag_clr) || wrap_evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    tick_timer_prescale #(
        .PRE_W (PRE_BITS)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (regs_q.ctrl.en),
        .restart (restart),
        .pre     (regs_q.ctrl.pre),
        .tick    (step_tick)
    );

    tick_timer_count #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step_tick),
        .restart     (restart),
        .restart_val (restart_val),
        .force_ld    (force_ld),
        .force_val   (wr_data),
        .reload_val  (reload_val),
        .count       (count),
        .wrap        (wrap_evt)
    );

    always_comb begin
        case (reg_addr)
            OFS_CTRL: rd_data = CNT_W'(pack_ctrl(regs_q.ctrl, regs_q.flag));
            OFS_MOD:  rd_data = regs_q.modv;
            OFS_CNT:  rd_data = count;
            default:  rd_data = '0;
        endcase
    end

    assign irq_o    = regs_q.flag && regs_q.ctrl.ie;
    assign flag_w   = regs_q.flag;
    assign en_w     = regs_q.ctrl.en;
    assign ie_w     = regs_q.ctrl.ie;
    assign ctrl_img = pack_ctrl(regs_q.ctrl, 1'b0);

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       reg_addr,
    input logic [CNT_W-1:0] wr_data,
    input logic             irq_o,
    input logic [CNT_W-1:0] count,
    input logic             step_tick,
    input logic             wrap_evt,
    input logic             flag_w,
    input logic             en_w,
    input logic             ie_w,
    input logic [CTL_W-1:0] ctrl_img
);
    logic [CTL_W-1:0] diff_mask;
    logic             wr_ctrl, wr_mod, wr_cnt;

    assign wr_ctrl   = wr_en && (reg_addr == OFS_CTRL);
    assign wr_mod    = wr_en && (reg_addr == OFS_MOD);
    assign wr_cnt    = wr_en && (reg_addr == OFS_CNT);
    assign diff_mask = (wr_data[CTL_W-1:0] ^ ctrl_img) & ~(CTL_W'(1) << CTL_IE) & ~(CTL_W'(1) << CTL_FLG);

    // R3: a write to the count offset never moves the count
    a_r3_cnt_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt && !step_tick |=> $stable(count));

    // R2: idle counter without restart or overwrite holds
    a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_w && !wr_ctrl && !wr_mod |=> $stable(count));

    // R2: no flag rises while disabled
    a_r2_no_flag_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_w && !flag_w |=> !flag_w);

    // R5: write-one clears the flag absent a same-edge event
    a_r5_flag_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && wr_data[CTL_FLG] && !wrap_evt |=> !flag_w);

    // R7: terminal count sets the flag
    a_r7_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> flag_w);

    // R8: modulus write clears the flag
    a_r8_mod_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mod && !wrap_evt |=> !flag_w);

    // R9: interrupt-only control write keeps the count
    a_r9_irq_only_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && (diff_mask == '0) && !step_tick |=> $stable(count));

    // R4: interrupt rises only together with a set enable
    a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ie_w);

endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .reg_addr  (reg_addr),
    .wr_data   (wr_data),
    .irq_o     (irq_o),
    .count     (count),
    .step_tick (step_tick),
    .wrap_evt  (wrap_evt),
    .flag_w    (flag_w),
    .en_w      (en_w),
    .ie_w      (ie_w),
    .ctrl_img  (ctrl_img)
);

// File: tb/tick_timer_tb_top.sv
`timescale 1ns/100ps
module tick_timer_tb_top;

    localparam int unsigned CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       reg_addr = 3'd0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [CNT_W-1:0] rd_data;
    logic             irq_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    typedef struct {
        bit               is_irq;
        logic [2:0]       addr;
        logic [CNT_W-1:0] exp;
        string            tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    tick_timer #(.CNT_W(CNT_W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .irq_o    (irq_o)
    );

    // Monitor: pops each expected item and compares it with the ports
    initial begin
        forever begin
            sb_item_t it;
            logic [CNT_W-1:0] act;
            wait (sb_q.size() != 0);
            #0.5;
            it  = sb_q[0];
            act = it.is_irq ? CNT_W'(irq_o) : rd_data;
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s: actual=0x%04h expected=0x%04h", it.tag, act, it.exp);
            end
            void'(sb_q.pop_front());
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One idle rising edge, then the write edge; returns on the falling edge after it
    task automatic wr(input logic [2:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        wr_en    = 1'b1;
        reg_addr = a;
        wr_data  = d;
        @(negedge clk);
        wr_en    = 1'b0;
    endtask

    task automatic exp_rd(input logic [2:0] a, input logic [CNT_W-1:0] e, input string tag);
        sb_item_t it;
        it.is_irq = 1'b0;
        it.addr   = a;
        it.exp    = e;
        it.tag    = tag;
        reg_addr  = a;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic exp_irq(input logic e, input string tag);
        sb_item_t it;
        it.is_irq = 1'b1;
        it.addr   = reg_addr;
        it.exp    = CNT_W'(e);
        it.tag    = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        exp_rd(3'd0, 16'h0000, "R1 ctrl after reset");
        exp_rd(3'd2, 16'h0000, "R1 modulus after reset");
        exp_irq(1'b0, "R1 irq after reset");
        step(1);
        exp_rd(3'd4, 16'hFFFF, "R1 count after reset");

        // R8: modulus write without overwrite leaves count
        wr(3'd2, 16'd5);
        exp_rd(3'd2, 16'd5, "R8 modulus readback");
        exp_rd(3'd4, 16'hFFFF, "R8 count untouched w/o overwrite");

        // R10/R6/R7: start reload mode, prescale 0 -> one step per 2 clocks
        wr(3'd0, 16'h000B);
        exp_rd(3'd4, 16'd5, "R10 restart loads modulus");
        exp_rd(3'd0, 16'h000B, "R3 ctrl readback");
        step(1);
        exp_rd(3'd4, 16'd5, "R6 no step after 1 clock");
        step(1);
        exp_rd(3'd4, 16'd4, "R6 step after 2 clocks");
        step(8);
        exp_rd(3'd4, 16'd0, "R6 count reaches 0");
        exp_irq(1'b0, "R4 irq low before wrap");
        step(2);
        exp_rd(3'd4, 16'd5, "R7 reload from modulus");
        exp_irq(1'b1, "R7 R4 irq after wrap");
        exp_rd(3'd0, 16'h000F, "R7 flag bit set");

        // R9/R5: flag clear only, lands on a step edge
        wr(3'd0, 16'h000F);
        exp_rd(3'd4, 16'd4, "R9 count undisturbed");
        exp_irq(1'b0, "R5 w1c clears");
        exp_rd(3'd0, 16'h000B, "R5 flag bit cleared");

        // R10/R6: prescale 1 -> one step per 4 clocks
        wr(3'd0, 16'h010B);
        exp_rd(3'd4, 16'd5, "R10 restart on prescale change");
        exp_rd(3'd0, 16'h010B, "R3 prescale readback");
        step(3);
        exp_rd(3'd4, 16'd5, "R6 no step after 3 clocks");
        step(1);
        exp_rd(3'd4, 16'd4, "R6 step after 4 clocks");

        // R8: overwrite wins over a same-edge step
        wr(3'd0, 16'h001B);
        wr(3'd2, 16'd9);
        exp_rd(3'd4, 16'd9, "R8 overwrite loads count");
        step(2);
        exp_rd(3'd4, 16'd8, "R8 counting from overwrite");

        // R8: no overwrite, new modulus used at next reload
        wr(3'd0, 16'h000B);
        wr(3'd2, 16'd2);
        exp_rd(3'd4, 16'd8, "R8 count kept w/o overwrite");
        step(18);
        exp_rd(3'd4, 16'd2, "R8 reload uses new modulus");
        exp_irq(1'b1, "R7 flag on wrap");
        wr(3'd2, 16'd3);
        exp_irq(1'b0, "R8 modulus write clears flag");
        exp_rd(3'd4, 16'd1, "R8 count untouched");
        step(4);
        exp_rd(3'd4, 16'd3, "R8 later reload uses 3");
        exp_irq(1'b1, "R7 flag again");

        // R5: writing 0 to the flag keeps it; R10 free mode restart
        wr(3'd0, 16'h0009);
        exp_rd(3'd4, 16'hFFFF, "R10 free mode restart 0xFFFF");
        exp_irq(1'b1, "R5 writing 0 keeps flag");
        exp_rd(3'd0, 16'h000D, "R5 ctrl with flag");
        step(2);
        exp_rd(3'd4, 16'hFFFE, "R6 free mode step");

        // R3: count write and unmapped write ignored
        wr(3'd4, 16'h1234);
        exp_rd(3'd4, 16'hFFFD, "R3 count write ignored");
        wr(3'd6, 16'hFFFF);
        exp_rd(3'd4, 16'hFFFC, "R3 unmapped write ignored");
        exp_rd(3'd0, 16'h000D, "R3 ctrl unchanged");
        exp_rd(3'd6, 16'h0000, "R3 unmapped reads 0");
        step(1);
        exp_rd(3'd2, 16'd3, "R3 modulus unchanged");

        // R7: free mode wrap reloads 0xFFFF
        wr(3'd0, 16'h001D);
        exp_irq(1'b0, "R5 w1c with restart");
        wr(3'd2, 16'd2);
        exp_rd(3'd4, 16'd2, "R8 overwrite in free mode");
        step(6);
        exp_rd(3'd4, 16'hFFFF, "R7 free mode reload 0xFFFF");
        exp_irq(1'b1, "R7 free mode flag");

        // R11: debug/doze stored; R2: hold while disabled
        wr(3'd0, 16'h006C);
        exp_rd(3'd0, 16'h0068, "R11 dbg doze readback");
        exp_irq(1'b0, "R5 flag cleared");
        wr(3'd0, 16'h0078);
        wr(3'd2, 16'd7);
        exp_rd(3'd4, 16'd7, "R2 overwrite while disabled");
        step(20);
        exp_rd(3'd4, 16'd7, "R2 count holds while disabled");
        exp_irq(1'b0, "R2 no flag while disabled");
        exp_rd(3'd0, 16'h0078, "R11 no effect on ctrl");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule